// File: doc/BRIEF.md
# Bit-Serial Table-Lookup Inner Product Engine

This block computes the dot product of four fixed coefficients with four input words without a single multiplier. The input words are signed two's-complement fractions that arrive one bit per clock, least significant bit first. All four words advance together, so each cycle the block sees a four-bit slice holding one bit from each word. That slice addresses a small table of precomputed coefficient sums. The table output is folded into a right-shifting accumulator.

A caller pulses `start` together with the first (least significant) bit slice and then presents one slice per cycle with no gaps. It raises `signTime` with the last slice, which carries the sign bits. In that cycle the table output is subtracted rather than added, and the final sum is registered on `result` with a one-cycle `resultValid` strobe. The coefficients are fixed at elaboration through a parameter. The result is an exact integer in units of 2^-(CF+N-1), where CF is the number of fraction bits in each coefficient and N is the word width.

Top module: `da_serial_dot`

## Requirements
- R1: While `rst` is high, `result` is cleared to zero and `resultValid` is held low.
- R2: Bit j of `bitSlice` carries the current bit of word j, and word 1 sits at the most significant slice position (j = K-1). The table entry for a slice is the sum of the coefficients of the words whose bit is 1. With the default coefficients (A1=737, A2=-307, A3=973, A4=113 in units of 2^-10), the all-ones slice selects 1516.
- R3: A frame is N consecutive cycles with the least significant bit first. `start` is high in the first cycle and treats the accumulator as zero. Each cycle that is not the sign cycle adds the table entry, aligned N-1 places up, and then shifts the accumulator right arithmetically by one.
- R4: In the sign cycle (`signTime` high) the aligned table entry is subtracted and no shift follows. `result` equals sum over k of A_k·x_k, where x_k is the N-bit two's-complement integer value of word k.
- R5: `resultValid` is high for exactly the one cycle after the sign cycle of a frame.
- R6: A `signTime` pulse outside a frame, meaning no `start` since the last sign cycle, is ignored. `resultValid` stays low and `result` keeps its value.
- R7: `result` holds its value from one completed frame until the next completed frame.
- R8: A `start` in the middle of a frame abandons the partial sum. The next result covers only the slices from that `start` on.
- R9: Four words of -1.0 (sign bit 1, all other bits 0) give exactly -(A1+A2+A3+A4)·2^(N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | High with the first bit slice of a frame |
| signTime | input | 1 | High with the last (sign) bit slice |
| bitSlice | input | K | One bit of each word; bit K-1 is word 1 |
| result | output | AW | Signed dot product, AW = CW + clog2(K) + N + 1 |
| resultValid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench builds the block with its default parameters: K=4 words of N=8 bits and 12-bit coefficients holding the four test values. Eight-bit words let a few hundred random frames cover every one of the sixteen table entries in every bit position, including the sign slot. The same setting also covers the extremes: all-minimum words, all-maximum words, and single words with one bit set. With 12-bit coefficients the integer reference product stays far inside the 23-bit result, so a comparison that matches exactly shows that no bit of the shifted sum was lost.

// File: rtl/da_pkg.sv
package da_pkg;

  typedef struct packed {
    logic clearAcc;    // treat accumulator as zero this cycle
    logic accumulate;  // add and shift this cycle
    logic subtract;    // subtract table entry instead of adding
    logic capture;     // register final sum on result
  } daCtrl_t;

endpackage

// File: rtl/da_coef_table.sv
module da_coef_table #(
  parameter int K = 4,
  parameter int CW = 12,
  parameter logic [K*CW-1:0] COEFS = '0,
  localparam int TW = CW + $clog2(K),
  localparam int DEPTH = 1 << K
) (
  input  logic [K-1:0]          addr,
  output logic signed [TW-1:0]  entry
);

  function automatic logic signed [TW-1:0] entryValue(input int idx);
    int sum;
    sum = 0;
    for (int j = 0; j < K; j++) begin
      if (((idx >> j) & 1) == 1) begin
        sum = sum + int'($signed(COEFS[j*CW +: CW]));
      end
    end
    return TW'(sum);
  endfunction

  logic signed [TW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign rom[i] = entryValue(i);
  end

  assign entry = rom[addr];

endmodule

// File: rtl/da_serial_ctrl.sv
module da_serial_ctrl
  import da_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    signTime,
  output daCtrl_t ctrl
);

  logic busy;
  logic active;

  assign active = start || busy;

  always_comb begin
    ctrl.clearAcc   = start;
    ctrl.accumulate = active && !signTime;
    ctrl.subtract   = signTime;
    ctrl.capture    = active && signTime;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (ctrl.capture) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
    end
  end

endmodule

// File: rtl/da_serial_datapath.sv
module da_serial_datapath
  import da_pkg::*;
#(
  parameter int N = 8,
  parameter int TW = 14,
  localparam int AW = TW + N + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  daCtrl_t              ctrl,
  input  logic signed [TW-1:0] entry,
  output logic signed [AW-1:0] result,
  output logic                 resultValid
);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] accBase;
  logic signed [AW-1:0] entryWide;
  logic signed [AW-1:0] weighted;
  logic signed [AW-1:0] combined;

  assign accBase   = ctrl.clearAcc ? '0 : acc;
  assign entryWide = {{(AW-TW){entry[TW-1]}}, entry};
  assign weighted  = entryWide <<< (N-1);
  assign combined  = ctrl.subtract ? (accBase - weighted) : (accBase + weighted);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctrl.capture;
      if (ctrl.accumulate) begin
        acc <= combined >>> 1;
      end
      if (ctrl.capture) begin
        result <= combined;
      end
    end
  end

endmodule

// File: rtl/da_serial_dot.sv
module da_serial_dot #(
  parameter int K = 4,
  parameter int N = 8,
  parameter int CW = 12,
  parameter logic [K*CW-1:0] COEFS = 48'h2E1_ECD_3CD_071,
  localparam int TW = CW + $clog2(K),
  localparam int AW = TW + N + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 signTime,
  input  logic [K-1:0]         bitSlice,
  output logic signed [AW-1:0] result,
  output logic                 resultValid
);

  da_pkg::daCtrl_t ctrl;
  logic signed [TW-1:0] entry;

  da_serial_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .signTime (signTime),
    .ctrl     (ctrl)
  );

  da_coef_table #(.K(K), .CW(CW), .COEFS(COEFS)) u_table (
    .addr  (bitSlice),
    .entry (entry)
  );

  da_serial_datapath #(.N(N), .TW(TW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .entry       (entry),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/da_serial_dot_checker.sv
module da_serial_dot_checker #(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          signTime,
  input logic [AW-1:0] result,
  input logic          resultValid
);

  logic inFrame;
  logic accepted;

  assign accepted = signTime && (start || inFrame);

  always_ff @(posedge clk) begin
    if (rst) inFrame <= 1'b0;
    else if (accepted) inFrame <= 1'b0;
    else if (start) inFrame <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!resultValid && result == '0)); // R1
  AST_VALID_ON_SIGN: assert property (@(posedge clk) disable iff (rst) accepted |=> resultValid); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst) !accepted |=> !resultValid); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !accepted |=> $stable(result)); // R7

endmodule

bind da_serial_dot da_serial_dot_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .signTime    (signTime),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/da_serial_dot_test.sv
module da_serial_dot_test;
  localparam int K = 4;
  localparam int N = 8;
  localparam int AW = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signTime = 1'b0;
  logic [K-1:0] bitSlice = '0;
  logic signed [AW-1:0] result;
  logic resultValid;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  // coefficient of slice j; word 1 at slice 3
  int coef [K] = '{113, 973, -307, 737};
  logic [N-1:0] words [K];

  always #10 clk = ~clk;

  da_serial_dot uut (
    .clk(clk), .rst(rst), .start(start), .signTime(signTime),
    .bitSlice(bitSlice), .result(result), .resultValid(resultValid)
  );

  function automatic longint expectDot();
    longint s = 0;
    for (int j = 0; j < K; j++) s += longint'(coef[j]) * longint'($signed(words[j]));
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic driveSlice(input int pos, input logic st, input logic sg);
    @(negedge clk);
    start = st;
    signTime = sg;
    for (int j = 0; j < K; j++) bitSlice[j] = words[j][pos];
  endtask

  task automatic runFrame(input string req);
    longint exp;
    exp = expectDot();
    for (int p = 0; p < N; p++) driveSlice(p, p == 0, p == N-1);
    @(negedge clk);
    start = 1'b0; signTime = 1'b0; bitSlice = '0;
    check({req, " R5 valid"}, longint'(resultValid), 1);
    check({req, " R4 result"}, longint'(result), exp);
    @(negedge clk);
    check("R5 single-cycle valid", longint'(resultValid), 0);
    check("R7 result held", longint'(result), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    longint held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(resultValid), 0);
    check("R1 reset result", longint'(result), 0);
    @(negedge clk);
    rst = 1'b0;

    // R4 zeros
    for (int j = 0; j < K; j++) words[j] = '0;
    runFrame("R4 zeros");

    // R9 all minimum, selects entry 1111 = 1516 (R2)
    for (int j = 0; j < K; j++) words[j] = 8'h80;
    runFrame("R9 all-min R2");
    check("R9 exact value", longint'(result), -1516 * 128);

    // all maximum
    for (int j = 0; j < K; j++) words[j] = 8'h7F;
    runFrame("R3 all-max");

    // R2 single word at a time, each coefficient alone
    for (int w = 0; w < K; w++) begin
      for (int j = 0; j < K; j++) words[j] = '0;
      words[w] = 8'h40;
      runFrame("R2 single word");
      check("R2 coefficient position", longint'(result), longint'(coef[w]) * 64);
    end

    // R2 address 1010 -> A1 + A3
    words[3] = 8'h01; words[2] = 8'h00; words[1] = 8'h01; words[0] = 8'h00;
    runFrame("R2 pattern 1010");
    check("R2 entry 1010", longint'(result), 737 + 973);

    // R6 stray sign pulse
    held = longint'(result);
    @(negedge clk);
    signTime = 1'b1; bitSlice = 4'hF;
    @(negedge clk);
    signTime = 1'b0; bitSlice = '0;
    @(negedge clk);
    check("R6 stray sign valid", longint'(resultValid), 0);
    check("R6 stray sign result", longint'(result), held);

    // R8 restart mid-frame
    for (int j = 0; j < K; j++) words[j] = 8'hFF;
    driveSlice(0, 1'b1, 1'b0);
    driveSlice(1, 1'b0, 1'b0);
    driveSlice(2, 1'b0, 1'b0);
    words[3] = 8'h12; words[2] = 8'hE5; words[1] = 8'h7A; words[0] = 8'h81;
    runFrame("R8 restart");

    // R3 R4 random frames
    for (int t = 0; t < 300; t++) begin
      for (int j = 0; j < K; j++) words[j] = N'($urandom);
      runFrame("R3 random");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule